// File: doc/BRIEF.md
# Packet and Word Token Rate Limiter

This block paces one egress port with a debt counter of the token-bucket kind. Every packet that starts adds a charge to the debt. The charge has two parts: a fixed per-packet part and a part proportional to the packet's length in 64-bit words. The debt falls by a fixed refill amount on every clock. A new packet may start only while the debt is within a burst ceiling, and a requester that is stalled waits until the allow output rises again.

Two settings give the two main uses. A word cost of zero turns the block into a packet-per-second shaper. A nonzero word cost, with the per-packet part covering the framing bytes that the word count leaves out, turns it into a bit-per-second shaper.

The per-packet cost and the ceiling are both held in units of 256 tokens, so they share one granularity. Software works out the three settings from the clock rate and the target rate, then loads them together with a single write strobe. When both costs are zero, limiting is off.

Top module: `rate_limiter`

## Requirements
- R1: After reset the debt is zero, all three settings are zero, and `allow` is high.
- R2: While `cfgWe` is high at a rising edge, the block loads the per-packet cost, the word cost and the ceiling together. The new values apply from the next cycle. A packet accepted in the same cycle as the write is charged with the old costs.
- R3: An accepted packet is charged `pktCost*256 + words*wordCost` tokens, where `words` is the value on `sopWords`. With a word cost of zero, the word count has no effect.
- R4: On every clock the debt falls by 16 tokens, and it stops at zero rather than wrapping below it.
- R5: Apart from the disabled case, `allow` is high exactly when debt <= ceiling*256. A debt equal to the ceiling still allows.
- R6: A `sopValid` that arrives while `allow` is low is ignored and adds nothing to the debt.
- R7: While both costs are zero, `allow` is high whatever the debt and the ceiling are.
- R8: When a packet is accepted, the next debt is max(debt-16, 0) plus that packet's charge.
- R9: The debt never wraps past its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Load strobe for the three settings |
| cfgPktCost | input | PKT_W | Per-packet cost, in units of 256 tokens |
| cfgWordCost | input | WCOST_W | Cost of one 64-bit word, in tokens |
| cfgLimit | input | LIM_W | Burst ceiling, in units of 256 tokens |
| sopValid | input | 1 | A packet asks to start |
| sopWords | input | WCNT_W | Length of that packet in 64-bit words |
| allow | output | 1 | A packet may start this cycle |

## Verification
The hardest situations to reach from the ports are those where the debt sits exactly on the ceiling, and those where the costs are switched to zero while a large debt is still outstanding. In both, `allow` reveals nothing about the counter until the debt has drained across the ceiling.

Directed steps handle both. One charge of 272 tokens against a ceiling of 256 leaves the debt at exactly 256 one cycle after a stall. A large per-packet cost piles up debt before zero costs are written, and limiting is then turned back on to show that the debt was kept.

Seeded random traffic uses small costs and small ceilings so that the debt crosses the ceiling often. It mixes in writes of new settings during traffic and zero-cost phases.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef struct packed {
    logic cfgLoad;
    logic charge;
  } rlStrobe_t;
endpackage

// File: rtl/rl_datapath.sv
module rl_datapath
  import rl_pkg::*;
#(
  parameter int PKT_W   = 12,
  parameter int WCOST_W = 16,
  parameter int LIM_W   = 16,
  parameter int WCNT_W  = 11,
  parameter int REFILL  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rlStrobe_t          strobe,
  input  logic [PKT_W-1:0]   pktCostIn,
  input  logic [WCOST_W-1:0] wordCostIn,
  input  logic [LIM_W-1:0]   limitIn,
  input  logic [WCNT_W-1:0]  sopWords,
  output logic               withinLimit,
  output logic               costsZero
);
  localparam int PKT_SH_W = PKT_W + 8;
  localparam int WRD_W    = WCOST_W + WCNT_W;
  localparam int COST_W   = ((PKT_SH_W > WRD_W) ? PKT_SH_W : WRD_W) + 1;
  localparam int LIM_SH_W = LIM_W + 8;
  localparam int DEBT_W   = ((COST_W > LIM_SH_W) ? COST_W : LIM_SH_W) + 1;

  logic [PKT_W-1:0]   pktCostQ;
  logic [WCOST_W-1:0] wordCostQ;
  logic [LIM_W-1:0]   limitQ;
  logic [DEBT_W-1:0]  debtQ, debtD, drained;
  logic [COST_W-1:0]  pktTerm, wordTerm, cost, wordsExt, wordCostExt;
  logic [DEBT_W-1:0]  ceiling;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCostQ  <= '0;
      wordCostQ <= '0;
      limitQ    <= '0;
    end else if (strobe.cfgLoad) begin
      pktCostQ  <= pktCostIn;
      wordCostQ <= wordCostIn;
      limitQ    <= limitIn;
    end
  end

  always_comb begin
    wordsExt    = {{(COST_W-WCNT_W){1'b0}}, sopWords};
    wordCostExt = {{(COST_W-WCOST_W){1'b0}}, wordCostQ};
    pktTerm     = {{(COST_W-PKT_SH_W){1'b0}}, pktCostQ, 8'h00};
    wordTerm    = wordsExt * wordCostExt;
    cost        = pktTerm + wordTerm;
    ceiling     = {{(DEBT_W-LIM_SH_W){1'b0}}, limitQ, 8'h00};
    drained     = (debtQ > DEBT_W'(REFILL)) ? debtQ - DEBT_W'(REFILL) : '0;
    debtD       = drained + (strobe.charge ? {{(DEBT_W-COST_W){1'b0}}, cost} : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) debtQ <= '0;
    else       debtQ <= debtD;
  end

  assign withinLimit = (debtQ <= ceiling);
  assign costsZero   = (pktCostQ == '0) && (wordCostQ == '0);

  // R4: refill removes REFILL tokens when no charge
  a_r4_drain: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.charge && debtQ >= DEBT_W'(REFILL)) |=> debtQ == $past(debtQ) - DEBT_W'(REFILL));
  // R4: saturation at zero
  a_r4_floor: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.charge && debtQ < DEBT_W'(REFILL)) |=> debtQ == '0);
  // R9: a charge never wraps the counter below the charged amount
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.charge |=> debtQ >= {{(DEBT_W-COST_W){1'b0}}, $past(cost)});
  // R2: settings load on strobe
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgLoad |=> (limitQ == $past(limitIn)) && (pktCostQ == $past(pktCostIn)));
endmodule

// File: rtl/rl_ctrl.sv
module rl_ctrl
  import rl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic      sopValid,
  input  logic      withinLimit,
  input  logic      costsZero,
  output logic      allow,
  output rlStrobe_t strobe
);
  always_comb begin
    allow          = costsZero | withinLimit;
    strobe.cfgLoad = cfgWe;
    strobe.charge  = sopValid & allow & ~costsZero;
  end

  // R6: no charge while stalled
  a_r6_stall_no_charge: assert property (@(posedge clk) disable iff (!rstN)
    !allow |-> !strobe.charge);
endmodule

// File: rtl/rate_limiter.sv
module rate_limiter
  import rl_pkg::*;
#(
  parameter int PKT_W   = 12,
  parameter int WCOST_W = 16,
  parameter int LIM_W   = 16,
  parameter int WCNT_W  = 11,
  parameter int REFILL  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [PKT_W-1:0]   cfgPktCost,
  input  logic [WCOST_W-1:0] cfgWordCost,
  input  logic [LIM_W-1:0]   cfgLimit,
  input  logic               sopValid,
  input  logic [WCNT_W-1:0]  sopWords,
  output logic               allow
);
  rlStrobe_t strobe;
  logic withinLimit, costsZero;

  rl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .sopValid(sopValid),
    .withinLimit(withinLimit), .costsZero(costsZero),
    .allow(allow), .strobe(strobe)
  );

  rl_datapath #(
    .PKT_W(PKT_W), .WCOST_W(WCOST_W), .LIM_W(LIM_W),
    .WCNT_W(WCNT_W), .REFILL(REFILL)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pktCostIn(cfgPktCost), .wordCostIn(cfgWordCost), .limitIn(cfgLimit),
    .sopWords(sopWords), .withinLimit(withinLimit), .costsZero(costsZero)
  );

  // R7: zero costs keep the port open
  a_r7_open_when_zero: assert property (@(posedge clk) disable iff (!rstN)
    costsZero |-> allow);
endmodule

// File: tb/tb_rate_limiter.sv
module tb_rate_limiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [11:0] cfgPktCost = '0;
  logic [15:0] cfgWordCost = '0;
  logic [15:0] cfgLimit = '0;
  logic sopValid = 1'b0;
  logic [10:0] sopWords = '0;
  logic allow;

  int checks = 0;
  int fails = 0;
  longint mDebt = 0;
  longint mPkt = 0, mWc = 0, mLim = 0;

  always #5 clk = ~clk;

  rate_limiter dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPktCost(cfgPktCost),
    .cfgWordCost(cfgWordCost), .cfgLimit(cfgLimit), .sopValid(sopValid),
    .sopWords(sopWords), .allow(allow)
  );

  function automatic bit expAllow();
    if (mPkt == 0 && mWc == 0) return 1'b1;          // R7
    return mDebt <= mLim * 256;                      // R5
  endfunction

  function automatic longint costOf(int words);
    return mPkt * 256 + longint'(words) * mWc;       // R3
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s allow actual=%0b expected=%0b (model debt %0d)", tag, act, exp, mDebt);
    end
  endtask

  task automatic step(string tag, bit sop, int words, bit we, int p, int w, int l);
    bit ea;
    longint c;
    @(negedge clk);
    ea = expAllow();
    check(tag, allow, ea);
    sopValid = sop; sopWords = 11'(words);
    cfgWe = we; cfgPktCost = 12'(p); cfgWordCost = 16'(w); cfgLimit = 16'(l);
    c = costOf(words);
    @(posedge clk);
    #1;
    mDebt = (mDebt > 16) ? mDebt - 16 : 0;           // R4
    if (sop && ea && !(mPkt == 0 && mWc == 0)) mDebt = mDebt + c;  // R6, R8
    if (we) begin mPkt = p; mWc = w; mLim = l; end   // R2
    sopValid = 1'b0; cfgWe = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R1", 1, 50, 0, 0, 0, 0);
    // R2, R3: load word cost 17, ceiling 1; charge 16 words = 272
    step("R2", 0, 0, 1, 0, 17, 1);
    step("R3", 1, 16, 0, 0, 0, 0);
    // R5: 272 > 256 -> stall; R6: request while stalled ignored
    step("R5", 1, 40, 0, 0, 0, 0);
    // R5 boundary: debt exactly 256 allowed; R6: nothing was added
    step("R6", 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    repeat (20) step("R4", 0, 0, 0, 0, 0, 0);
    // R8: per-packet cost 100, ceiling 0, charge in same cycle as write uses old costs (R2)
    step("R2", 1, 0, 1, 100, 0, 0);
    step("R8", 1, 5, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);
    // R7: zero costs open the port despite large debt
    step("R7", 0, 0, 1, 0, 0, 0);
    step("R7", 1, 30, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 1, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    repeat (1700) step("R4", 0, 0, 0, 0, 0, 0);
    // R3 packet mode: word cost zero, words ignored
    step("R3", 0, 0, 1, 2, 0, 2);
    step("R3", 1, 2000, 0, 0, 0, 0);
    step("R3", 1, 7, 0, 0, 0, 0);
    repeat (40) step("R3", 1, 1000, 0, 0, 0, 0);
    // Random traffic: R5 R6 R8 R9
    for (int i = 0; i < 6000; i++) begin
      bit we;
      int p, w, l;
      we = ($urandom % 60) == 0;
      p = ($urandom % 5 == 0) ? 0 : int'($urandom % 4);
      w = ($urandom % 5 == 0) ? 0 : int'($urandom % 9);
      l = int'($urandom % 5);
      step("R5", ($urandom % 2) == 1, int'($urandom % 41), we, p, w, l);
    end
    // R9: largest costs do not wrap
    step("R9", 0, 0, 1, 4095, 65535, 65535);
    step("R9", 1, 2047, 0, 0, 0, 0);
    repeat (10) step("R9", 1, 2047, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule